// File: doc/BRIEF.md
# SPI Serial Clock Generator with Encoded Divisor

This block makes the serial clock for a SPI master from the system clock. A compact divisor code selects how many system-clock cycles form one serial-clock period. The code is not a plain binary count. It is an interleaved encoding in which the largest code gives the fastest clock. An optional high nibble adds whole multiples of sixteen cycles, which allows slow clocks for long links.

Alongside the clock, the block produces two one-cycle strobes in the system-clock domain for the shift engine. The sample strobe marks each rising serial-clock edge and the launch strobe marks each falling edge. The divider counts only while a transfer is active. Between transfers the serial clock rests low. The divisor is captured when a transfer begins, so a new code applied during a transfer waits for the next one.

Top module: `spi_sck_gen`

## Requirements
- R1: With the high nibble zero, the low code c sets the period N. For c with bit 3 set, N = 2*(15-c)+1. For c with bit 3 clear, N = 16-2*c. For example, code 15 gives 1, code 7 gives 2, code 14 gives 3 and code 0 gives 16.
- R2: With the extended variant enabled (EXT_HI=1), the period is N = 16*hi + ratio(lo), up to 256. With EXT_HI=0 the high nibble has no effect.
- R3: For N >= 2, the clock rises in the first cycle after the posedge that samples xfer_active_i high. It stays high for floor(N/2) cycles and low for the remaining cycles, and repeats every N cycles.
- R4: For N >= 2, sample_o is high only in the first high cycle of each period, and launch_o is high only in the first low cycle (cycle floor(N/2)). The two strobes never coincide.
- R5: While no transfer runs, and after reset, sck_o, launch_o and sample_o are all low.
- R6: When xfer_active_i drops, the current period completes, and the block then goes idle at the period boundary. A transfer held active for A sampled cycles therefore produces ceil(A/N) full periods.
- R7: A change to the divisor inputs while the clock runs has no effect until the block has gone idle and a new transfer starts.
- R8: For N = 1, sck_o follows the system clock while running, and both strobes are high in every running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_active_i | input | 1 | High while a transfer wants the serial clock |
| div_lo_i | input | 4 | Encoded divisor code |
| div_hi_i | input | 4 | High divisor nibble, counted in units of 16 cycles |
| sck_o | output | 1 | Serial clock, idle low |
| launch_o | output | 1 | One-cycle strobe on each falling serial-clock edge |
| sample_o | output | 1 | One-cycle strobe on each rising serial-clock edge |

## Verification
Bursts use codes from both halves of the interleaved encoding. The set includes odd and even periods, the pass-through ratio of one, and the slowest code, which separates a correct decode from a plain binary one and shows the uneven split of odd periods. One burst sets the high nibble, and the maximum period of 256 checks that the extension adds rather than replaces. The active time is chosen so that it does not fill a whole period, which shows that the block finishes the period instead of cutting it short. A code change in the middle of a run is shown to take hold only in the next burst.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  localparam int CW = 4;
  localparam int DW = 2 * CW + 1;
  typedef logic [DW-1:0] div_t;

  // Interleaved decode: top bit set -> odd ratios, clear -> even ratios.
  function automatic div_t ratio_of(input logic [CW-1:0] c);
    int v;
    v = int'(c);
    if (c[CW-1]) return div_t'(2 * ((1 << CW) - 1 - v) + 1);
    return div_t'((1 << CW) - 2 * v);
  endfunction
endpackage

// File: rtl/sck_div_decode.sv
module sck_div_decode
  import spi_sck_pkg::*;
#(
  parameter bit EXT_HI = 1'b1
) (
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output div_t          div_o
);
  logic [CW-1:0] hi_eff;

  generate
    if (EXT_HI) begin : g_ext
      assign hi_eff = hi_i;
    end else begin : g_base
      assign hi_eff = hi_i & {CW{1'b0}};
    end
  endgenerate

  assign div_o = ratio_of(lo_i) + {1'b0, hi_eff, {CW{1'b0}}};
endmodule

// File: rtl/sck_div_seq.sv
module sck_div_seq
  import spi_sck_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  div_t div_i,
  output logic run_o,
  output div_t cnt_o,
  output div_t div_q_o
);
  logic period_end;

  assign period_end = (cnt_o == div_q_o - div_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      cnt_o   <= '0;
      div_q_o <= div_t'(1);
    end else if (!run_o) begin
      if (active_i) begin
        run_o   <= 1'b1;
        cnt_o   <= '0;
        div_q_o <= div_i;
      end
    end else if (period_end) begin
      cnt_o <= '0;
      if (!active_i) run_o <= 1'b0;
    end else begin
      cnt_o <= cnt_o + div_t'(1);
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (cnt_o < div_q_o));

  // R6
  stop_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> ($past(cnt_o) == $past(div_q_o) - div_t'(1)));

  // R7
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(div_q_o));
endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen
  import spi_sck_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  div_t cnt_i,
  input  div_t div_q_i,
  output logic sck_o,
  output logic launch_o,
  output logic sample_o
);
  div_t half;
  logic bypass;
  logic high_phase;

  assign half       = div_q_i >> 1;
  assign bypass     = (div_q_i == div_t'(1));
  assign high_phase = bypass ? clk_i : (cnt_i < half);

  assign sck_o    = run_i & high_phase;
  assign sample_o = run_i & (cnt_i == '0);
  assign launch_o = run_i & (cnt_i == half);

  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!sample_o && !launch_o && !sck_o));

  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass |-> !(sample_o && launch_o));

  // R4
  sample_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !bypass) |-> sck_o);
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_sck_pkg::*;
#(
  parameter bit EXT_HI = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xfer_active_i,
  input  logic [CW-1:0] div_lo_i,
  input  logic [CW-1:0] div_hi_i,
  output logic          sck_o,
  output logic          launch_o,
  output logic          sample_o
);
  div_t div_new;
  div_t div_cur;
  div_t cnt;
  logic run;

  sck_div_decode #(.EXT_HI(EXT_HI)) u_decode (
    .lo_i  (div_lo_i),
    .hi_i  (div_hi_i),
    .div_o (div_new)
  );

  sck_div_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (xfer_active_i),
    .div_i    (div_new),
    .run_o    (run),
    .cnt_o    (cnt),
    .div_q_o  (div_cur)
  );

  sck_edge_gen u_edges (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .cnt_i    (cnt),
    .div_q_i  (div_cur),
    .sck_o    (sck_o),
    .launch_o (launch_o),
    .sample_o (sample_o)
  );
endmodule

// File: tb/spi_sck_gen_tb.sv
`timescale 1ns/1ps
module spi_sck_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic active = 1'b0;
  logic [3:0] lo = 4'd0;
  logic [3:0] hi = 4'd0;
  logic sck, lch, smp;

  always #2.5 clk = ~clk;

  spi_sck_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .xfer_active_i(active),
    .div_lo_i(lo), .div_hi_i(hi),
    .sck_o(sck), .launch_o(lch), .sample_o(smp)
  );

  typedef struct { logic s; logic l; logic m; string tag; } exp_t;
  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Ratio k+1 is selected by code order_tab[k] (R1).
  int order_tab[16] = '{15, 7, 14, 6, 13, 5, 12, 4, 11, 3, 10, 2, 9, 1, 8, 0};

  function automatic int ratio_ref(int code);
    for (int k = 0; k < 16; k++) if (order_tab[k] == code) return k + 1;
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per cycle, sampled 1 ns after posedge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, "sck", sck, e.s);
        check(e.tag, "launch", lch, e.l);
        check(e.tag, "sample", smp, e.m);
      end
    end
  end

  // Driver: holds active for act_cyc sampled edges and switches the code to new_lo mid-run.
  task automatic burst(int c_lo, int c_hi, int act_cyc, int new_lo, string tag);
    int n, p;
    exp_t e;
    n = 16 * c_hi + ratio_ref(c_lo);
    p = (act_cyc + n - 1) / n;   // R6: whole periods only
    @(negedge clk);
    lo = 4'(c_lo); hi = 4'(c_hi); active = 1'b1;
    for (int k = 0; k < p; k++)
      for (int j = 0; j < n; j++) begin
        e.s = (n == 1) ? 1'b1 : (j < n / 2);  // R3 high floor(N/2), R8 pass-through
        e.l = (j == n / 2);                   // R4 launch at first low cycle
        e.m = (j == 0);                       // R4 sample at first high cycle
        e.tag = tag;
        q.push_back(e);
      end
    for (int j = 0; j < 3; j++) begin
      e.s = 1'b0; e.l = 1'b0; e.m = 1'b0; e.tag = "R5";
      q.push_back(e);
    end
    for (int c = 1; c < act_cyc; c++) begin
      @(negedge clk);
      if (c == 1) lo = 4'(new_lo);   // R7: ignored while running
    end
    @(negedge clk);
    active = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R5", "sck in reset", sck, 0);
    check("R5", "launch in reset", lch, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5", "sck after reset", sck, 0);
    check("R5", "sample after reset", smp, 0);
    burst(15, 0, 3, 15, "R8");
    burst(7, 0, 4, 7, "R3");
    burst(14, 0, 3, 14, "R3");
    burst(12, 0, 7, 12, "R4");
    burst(0, 0, 1, 0, "R1");
    burst(11, 0, 2, 11, "R1");
    burst(6, 1, 21, 6, "R6");
    burst(13, 0, 6, 0, "R7");
    burst(0, 0, 1, 0, "R7");
    burst(0, 15, 1, 0, "R2");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule